// File: doc/BRIEF.md
# Linear Sensor Readout Timing Generator

This block is the digital sequencer of a linear photodiode-array readout chip. It takes a master clock and a single integration pulse. From these two it derives every strobe the analog side needs: the charge-amplifier reset, a correlated-double-sampling hold strobe, a one-hot pixel select for the shift register, a per-pixel conversion trigger for an external ADC, and a one-cycle end-of-readout flag.

The charge amplifiers are held in reset for as long as the integration pulse is high, so the pulse width alone sets the integration time. When the pulse is seen low, a short fixed lead-in follows. The sequencer then walks pixel 0 up to pixel `N_PIX-1`, giving each one an 8-clock slot, so the pixel rate is the clock rate divided by 8. A new integration pulse at any point aborts the readout in progress.

Top module: `lin_rdout_seq`

## Requirements
- R1: After the synchronous active-high `rst`, with `integ` low, every output is 0: `amp_rst`, `cds_hold`, `adc_trig`, `rd_done` and all bits of `pix_sel`.
- R2: `amp_rst` is high in the cycle after each clock edge that samples `integ` high, and it stays high while `integ` stays high. It is low during lead-in and readout.
- R3: Call the first clock edge that samples `integ` low after it was high E1. Readout starts two clocks later: `pix_sel[0]` first goes high after edge E3.
- R4: Pixel p (counted from 0) is selected for exactly 8 consecutive cycles, after edges E3+8p through E3+8p+7. Pixels come in ascending order.
- R5: `pix_sel` is one-hot while a pixel is selected and all-zero at every other time.
- R6: `adc_trig` is high for exactly one cycle per pixel, in slot cycle 6 of that pixel's slot (after edge E3+8p+6). A full readout gives `N_PIX` pulses.
- R7: `cds_hold` is high for exactly one cycle per pixel, in slot cycle 1 (after edge E3+8p+1).
- R8: `rd_done` is high for exactly one cycle, after edge E3+8·N_PIX, and `pix_sel` is zero in that cycle. It is not raised otherwise.
- R9: If `integ` is sampled high during lead-in or readout, the sequence is aborted at that edge. In the following cycle `amp_rst` is 1, `pix_sel`, `adc_trig` and `cds_hold` are 0, and no `rd_done` is raised for the aborted readout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| integ | input | 1 | Integration pulse; its high width is the integration time |
| amp_rst | output | 1 | Charge-amplifier feedback reset strobe |
| cds_hold | output | 1 | Post-reset level hold strobe for CDS |
| adc_trig | output | 1 | Conversion trigger, one per pixel |
| pix_sel | output | N_PIX | One-hot shift-register pixel select |
| rd_done | output | 1 | One-cycle flag after the last pixel |

## Verification
The bench aims at the edges of the sequence.

- **Lead-in length.** Readout start is checked exactly two clocks after the falling edge. A lead-in that is off by one shifts every select and trigger, and that shows up in the very first readout cycle.
- **Slot boundaries.** The last slot cycle of each pixel and the last pixel are checked. A slot counter with the wrong wrap would give a 7- or 9-cycle pixel, or a missing or doubled `rd_done`.
- **Aborts.** Aborts are placed in the lead-in, in mid-slot, and on the final slot cycle. A design that lets the final edge win over the abort would flag a completed readout that never happened.
- **Pulse widths.** Integration widths of a single cycle and random longer widths are mixed in, which exposes an edge detector that misses short pulses.

// File: rtl/rt_pkg.sv
package rt_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_INTEG = 2'd1,
    ST_LEAD  = 2'd2,
    ST_READ  = 2'd3
  } rt_state_e;
endpackage

// File: rtl/rt_edge.sv
module rt_edge (
  input  logic clk,
  input  logic rst,
  input  logic integ,
  output logic integ_fall
);
  logic integ_q;

  always_ff @(posedge clk) begin
    if (rst) integ_q <= 1'b0;
    else     integ_q <= integ;
  end

  assign integ_fall = integ_q & ~integ;

  // R3
  fall_needs_prior_high_chk: assert property (@(posedge clk) disable iff (rst)
    integ_fall |-> $past(integ));
endmodule

// File: rtl/rt_seq_fsm.sv
module rt_seq_fsm
  import rt_pkg::*;
#(
  parameter int N_PIX     = 16,
  parameter int SLOT_CLKS = 8,
  parameter int LEAD_CLKS = 2
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          integ,
  input  logic                          integ_fall,
  output rt_state_e                     nxt_state,
  output logic [$clog2(SLOT_CLKS)-1:0]  nxt_slot,
  output logic [$clog2(N_PIX)-1:0]      nxt_pix,
  output logic                          fin
);
  localparam int PIX_W  = $clog2(N_PIX);
  localparam int SLOT_W = $clog2(SLOT_CLKS);
  localparam int LEAD_W = $clog2(LEAD_CLKS) + 1;
  localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(SLOT_CLKS - 1);
  localparam logic [PIX_W-1:0]  PIX_LAST  = PIX_W'(N_PIX - 1);
  localparam logic [LEAD_W-1:0] LEAD_LAST = LEAD_W'(LEAD_CLKS - 1);

  rt_state_e          state;
  logic [SLOT_W-1:0]  slot;
  logic [PIX_W-1:0]   pix;
  logic [LEAD_W-1:0]  lead, nxt_lead;

  always_comb begin
    nxt_state = state;
    nxt_slot  = slot;
    nxt_pix   = pix;
    nxt_lead  = lead;
    fin       = 1'b0;
    if (integ) begin
      nxt_state = ST_INTEG;
      nxt_slot  = '0;
      nxt_pix   = '0;
      nxt_lead  = '0;
    end else begin
      unique case (state)
        ST_INTEG: if (integ_fall) begin
          nxt_state = ST_LEAD;
          nxt_lead  = '0;
        end
        ST_LEAD: begin
          if (lead == LEAD_LAST) begin
            nxt_state = ST_READ;
            nxt_slot  = '0;
            nxt_pix   = '0;
          end else begin
            nxt_lead = lead + 1'b1;
          end
        end
        ST_READ: begin
          if (slot == SLOT_LAST) begin
            nxt_slot = '0;
            if (pix == PIX_LAST) begin
              nxt_state = ST_IDLE;
              nxt_pix   = '0;
              fin       = 1'b1;
            end else begin
              nxt_pix = pix + 1'b1;
            end
          end else begin
            nxt_slot = slot + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      slot  <= '0;
      pix   <= '0;
      lead  <= '0;
    end else begin
      state <= nxt_state;
      slot  <= nxt_slot;
      pix   <= nxt_pix;
      lead  <= nxt_lead;
    end
  end

  // R8
  last_slot_to_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_READ && slot == SLOT_LAST && pix == PIX_LAST && !integ) |=> state == ST_IDLE);

  // R9
  abort_to_integ_chk: assert property (@(posedge clk) disable iff (rst)
    integ |=> state == ST_INTEG);

  // R4
  slot_step_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_READ && !integ && slot != SLOT_LAST) |=>
      (slot == $past(slot) + 1'b1 && pix == $past(pix)));
endmodule

// File: rtl/rt_out_reg.sv
module rt_out_reg
  import rt_pkg::*;
#(
  parameter int N_PIX     = 16,
  parameter int SLOT_CLKS = 8,
  parameter int TRIG_SLOT = 6,
  parameter int HOLD_SLOT = 1
) (
  input  logic                          clk,
  input  logic                          rst,
  input  rt_state_e                     nxt_state,
  input  logic [$clog2(SLOT_CLKS)-1:0]  nxt_slot,
  input  logic [$clog2(N_PIX)-1:0]      nxt_pix,
  input  logic                          fin,
  output logic                          amp_rst,
  output logic                          cds_hold,
  output logic                          adc_trig,
  output logic [N_PIX-1:0]              pix_sel,
  output logic                          rd_done
);
  localparam int SLOT_W = $clog2(SLOT_CLKS);
  localparam int PIX_W  = $clog2(N_PIX);

  logic reading;
  assign reading = (nxt_state == ST_READ);

  always_ff @(posedge clk) begin
    if (rst) begin
      amp_rst  <= 1'b0;
      cds_hold <= 1'b0;
      adc_trig <= 1'b0;
      rd_done  <= 1'b0;
    end else begin
      amp_rst  <= (nxt_state == ST_INTEG);
      cds_hold <= reading && (nxt_slot == SLOT_W'(HOLD_SLOT));
      adc_trig <= reading && (nxt_slot == SLOT_W'(TRIG_SLOT));
      rd_done  <= fin;
    end
  end

  for (genvar g = 0; g < N_PIX; g++) begin : g_sel
    always_ff @(posedge clk) begin
      if (rst) pix_sel[g] <= 1'b0;
      else     pix_sel[g] <= reading && (nxt_pix == PIX_W'(g));
    end
  end

  // R5
  sel_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(pix_sel));

  // R6
  trig_single_chk: assert property (@(posedge clk) disable iff (rst)
    adc_trig |=> !adc_trig);

  // R6
  trig_has_pixel_chk: assert property (@(posedge clk) disable iff (rst)
    adc_trig |-> $countones(pix_sel) == 1);

  // R7
  hold_single_chk: assert property (@(posedge clk) disable iff (rst)
    cds_hold |=> !cds_hold);

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    rd_done |-> (pix_sel == '0 && !rd_done == 1'b0));

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    rd_done |=> !rd_done);

  // R2
  reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    amp_rst |-> (pix_sel == '0 && !adc_trig && !cds_hold));
endmodule

// File: rtl/lin_rdout_seq.sv
module lin_rdout_seq
  import rt_pkg::*;
#(
  parameter int N_PIX     = 16,
  parameter int SLOT_CLKS = 8,
  parameter int LEAD_CLKS = 2,
  parameter int TRIG_SLOT = 6,
  parameter int HOLD_SLOT = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             integ,
  output logic             amp_rst,
  output logic             cds_hold,
  output logic             adc_trig,
  output logic [N_PIX-1:0] pix_sel,
  output logic             rd_done
);
  localparam int SLOT_W = $clog2(SLOT_CLKS);
  localparam int PIX_W  = $clog2(N_PIX);

  logic              integ_fall;
  rt_state_e         nxt_state;
  logic [SLOT_W-1:0] nxt_slot;
  logic [PIX_W-1:0]  nxt_pix;
  logic              fin;

  rt_edge u_edge (
    .clk        (clk),
    .rst        (rst),
    .integ      (integ),
    .integ_fall (integ_fall)
  );

  rt_seq_fsm #(
    .N_PIX     (N_PIX),
    .SLOT_CLKS (SLOT_CLKS),
    .LEAD_CLKS (LEAD_CLKS)
  ) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .integ      (integ),
    .integ_fall (integ_fall),
    .nxt_state  (nxt_state),
    .nxt_slot   (nxt_slot),
    .nxt_pix    (nxt_pix),
    .fin        (fin)
  );

  rt_out_reg #(
    .N_PIX     (N_PIX),
    .SLOT_CLKS (SLOT_CLKS),
    .TRIG_SLOT (TRIG_SLOT),
    .HOLD_SLOT (HOLD_SLOT)
  ) u_out (
    .clk       (clk),
    .rst       (rst),
    .nxt_state (nxt_state),
    .nxt_slot  (nxt_slot),
    .nxt_pix   (nxt_pix),
    .fin       (fin),
    .amp_rst   (amp_rst),
    .cds_hold  (cds_hold),
    .adc_trig  (adc_trig),
    .pix_sel   (pix_sel),
    .rd_done   (rd_done)
  );
endmodule

// File: tb/tb_lin_rdout_seq.sv
module tb_lin_rdout_seq;
  localparam int N = 16;
  localparam int LAST_C = 3 + 8 * N;

  logic clk = 1'b0;
  logic rst, integ;
  logic amp_rst, cds_hold, adc_trig, rd_done;
  logic [N-1:0] pix_sel;
  int n_chk = 0, n_fail = 0, cyc = 0;

  always #10 clk = ~clk;

  lin_rdout_seq #(.N_PIX(N)) dut (
    .clk(clk), .rst(rst), .integ(integ), .amp_rst(amp_rst), .cds_hold(cds_hold),
    .adc_trig(adc_trig), .pix_sel(pix_sel), .rd_done(rd_done));

  task automatic chk(string tag, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic logic [N-1:0] exp_sel(int c);
    if (c >= 3 && c < LAST_C) return N'(1) << ((c - 3) / 8);
    return '0;
  endfunction

  function automatic logic exp_slot(int c, int s);
    return (c >= 3 && c < LAST_C) && ((c - 3) % 8 == s);
  endfunction

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
    end
  end

  // One integration pulse of width w, then readout; abort_c > 0 aborts after edge E(abort_c).
  task automatic run(int w, int abort_c);
    @(negedge clk) integ = 1'b1;
    for (int i = 0; i < w; i++) begin
      @(negedge clk);
      chk("R2 amp_rst during integ", amp_rst, 1);
      chk("R5 sel during integ", pix_sel, 0);
    end
    integ = 1'b0;
    for (int c = 1; c <= LAST_C + 1; c++) begin
      @(negedge clk);
      chk("R2 amp_rst off", amp_rst, 0);
      if (c == 3) chk("R3 first pixel", pix_sel, 1);
      chk("R4 R5 pix_sel", pix_sel, exp_sel(c));
      chk("R6 adc_trig", adc_trig, exp_slot(c, 6));
      chk("R7 cds_hold", cds_hold, exp_slot(c, 1));
      chk("R8 rd_done", rd_done, (c == LAST_C));
      if (c == abort_c) begin
        integ = 1'b1;
        @(negedge clk);
        chk("R9 abort amp_rst", amp_rst, 1);
        chk("R9 abort sel", pix_sel, 0);
        chk("R9 abort trig", adc_trig, 0);
        chk("R9 abort hold", cds_hold, 0);
        chk("R9 abort no done", rd_done, 0);
        @(negedge clk);
        chk("R9 no late done", rd_done, 0);
        integ = 1'b0;
        @(negedge clk);
        return;
      end
    end
  endtask

  initial begin
    void'($urandom(32'd4711));
    rst = 1'b1; integ = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 amp_rst", amp_rst, 0);
    chk("R1 pix_sel", pix_sel, 0);
    chk("R1 adc_trig", adc_trig, 0);
    chk("R1 cds_hold", cds_hold, 0);
    chk("R1 rd_done", rd_done, 0);
    rst = 1'b0;
    repeat (4) begin
      @(negedge clk);
      chk("R1 idle quiet", {amp_rst, cds_hold, adc_trig, rd_done, pix_sel}, 0);
    end
    run(1, 0);
    run(5, 0);
    run(3, 1);
    run(2, 2);
    run(4, LAST_C - 1);
    run(1, 10);
    run(2, 0);
    for (int k = 0; k < 25; k++) begin
      int w, a;
      w = 1 + int'($urandom % 20);
      a = ($urandom % 3 == 0) ? 1 + int'($urandom % (LAST_C - 1)) : 0;
      run(w, a);
    end
    summary();
  end
endmodule